// File: doc/BRIEF.md
# Vertical Countdown Processor with Field-Rate Identification

This block tracks vertical timing in a video path from a clock enable that pulses twice per line, so every count is in half lines. It watches a separated vertical sync input and restarts its field counter when a sync rising edge lands inside a length window chosen by a 3-bit mode. A sync edge outside that window has no effect. If no usable edge arrives, the field ends at the window's upper bound. Four of the eight modes ignore sync completely and produce fields of a fixed length.

At every field end the block emits a one-clock restart pulse and starts a vertical output pulse of fixed width. It also classifies the length of the field just ended. One flag reports 60 Hz versus 50 Hz, one reports a length that is not one of the two standard values, and one reports whether sync is being followed.

Top module: `vert_countdown`

## Requirements
- R1: After a synchronous active-low reset, `vreset`, `vout`, `is_60hz`, `nonstd` and `locked` are all 0.
- R2: The field counter advances only on clocks with `hh_en` high. A field end drives `vreset` high for exactly one clock, and the field length is the number of `hh_en` ticks between two `vreset` pulses.
- R3: Modes 3'b000 and 3'b100 accept a sync rising edge when it makes the current field length L satisfy lo ≤ L ≤ 706, with lo = 449 for 3'b000 and lo = 65 for 3'b100. An accepted edge ends the field at length L.
- R4: Modes 3'b001 and 3'b101 accept a sync edge when lo ≤ L ≤ 594, with lo = 449 for 3'b001 and lo = 65 for 3'b101.
- R5: A sync edge outside the window is ignored. When no edge is accepted, the field ends at 706 half lines in modes 000/100 and at 594 in modes 001/101.
- R6: Modes with bit 1 set ignore sync and produce fixed lengths: 3'b010 gives 525, 3'b011 gives 625, 3'b110 gives 524 and 3'b111 gives 624.
- R7: `vout` rises together with `vreset` and stays high for exactly 16 half-line ticks.
- R8: At each field end, `is_60hz` is set to 1 when the ended field is shorter than 575 half lines and to 0 otherwise. It holds its value between field ends.
- R9: At each field end, `nonstd` is set to 0 when the length is exactly 525 or 625 and to 1 for any other length.
- R10: `locked` is set by a field that ends on an accepted sync edge. It is cleared when two consecutive fields end without one. A single missed field leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hh_en | input | 1 | Half-line clock enable |
| vsync_in | input | 1 | Separated vertical sync; its rising edge is used |
| mode | input | 3 | Window or forced-length mode select |
| vreset | output | 1 | One-clock pulse at each field end |
| vout | output | 1 | Vertical output pulse, 16 half lines wide |
| is_60hz | output | 1 | Last field was classed as 60 Hz |
| nonstd | output | 1 | Last field length was not a standard length |
| locked | output | 1 | Sync is being followed |

## Verification
A sync rising edge is acted on at the `hh_en` edge where it is first sampled. `vreset` and all three flags take their new values on that same edge, so they are readable one falling edge later. The bench therefore drives `vsync_in` on the falling edge just before the target tick. It measures the field length as the number of falling edges from one observed `vreset` to the next, and it reads the flags at the falling edge where `vreset` is seen. `vout` is sampled at every falling edge of the field and must be high on exactly 16 of them, the first being the `vreset` sample.

// File: rtl/vcd_pkg.sv
// Package: shared constants for the vertical countdown processor.
// Assumes all lengths are expressed in half lines.
package vcd_pkg;
    localparam int MODE_W = 3;
endpackage

// File: rtl/vcd_window.sv
// Module: vcd_window
// Decodes the 3-bit mode into an acceptance window (lo..limit) and a sync
// enable. In the forced modes, lo equals limit and sync is disabled.
// Assumes the mode is static or changes only at a field boundary.
module vcd_window #(
    parameter int HL_W      = 10,
    parameter int NARROW_LO = 449,
    parameter int WIDE_LO   = 65,
    parameter int HI_AUTO   = 706,
    parameter int HI_60     = 594,
    parameter int F_525     = 525,
    parameter int F_625     = 625,
    parameter int F_524     = 524,
    parameter int F_624     = 624
) (
    input  logic [vcd_pkg::MODE_W-1:0] mode,
    output logic [HL_W-1:0]            lo,
    output logic [HL_W-1:0]            limit,
    output logic                       sync_en
);
    // Purpose: map the mode bits to window bounds or a fixed length.
    always_comb begin
        sync_en = !mode[1];
        if (mode[1]) begin
            if (mode[0]) limit = mode[2] ? HL_W'(F_624) : HL_W'(F_625);
            else         limit = mode[2] ? HL_W'(F_524) : HL_W'(F_525);
            lo = limit;
        end else begin
            lo    = mode[2] ? HL_W'(WIDE_LO) : HL_W'(NARROW_LO);
            limit = mode[0] ? HL_W'(HI_60)   : HL_W'(HI_AUTO);
        end
    end
endmodule

// File: rtl/vcd_counter.sv
// Module: vcd_counter
// Half-line field counter. It detects sync rising edges, holds an edge that
// arrives between ticks until the next tick, and ends the field on an
// in-window edge or when the length reaches the limit.
// Assumes limit never exceeds MAX_HL.
module vcd_counter #(
    parameter int HL_W   = 10,
    parameter int MAX_HL = 706
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hh_en,
    input  logic            vsync_in,
    input  logic [HL_W-1:0] lo,
    input  logic [HL_W-1:0] limit,
    input  logic            sync_en,
    output logic [HL_W-1:0] cnt_q,
    output logic [HL_W-1:0] len_now,
    output logic            acc_now,
    output logic            end_now
);
    logic sync_d;
    logic pend_q;
    logic rise;

    // Purpose: detect edges and decide acceptance and field end.
    always_comb begin
        rise    = vsync_in && !sync_d;
        len_now = cnt_q + HL_W'(1);
        acc_now = hh_en && sync_en && (pend_q || rise) &&
                  (len_now >= lo) && (len_now <= limit);
        end_now = hh_en && (acc_now || (len_now >= limit));
    end

    // Purpose: advance or restart the counter and track pending edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            sync_d <= 1'b0;
        end else begin
            sync_d <= vsync_in;
            if (hh_en) begin
                pend_q <= 1'b0;
                cnt_q  <= end_now ? '0 : len_now;
            end else if (rise) begin
                pend_q <= 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < HL_W'(MAX_HL)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hh_en |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/vcd_pulse.sv
// Module: vcd_pulse
// Produces the one-clock restart pulse and the fixed-width vertical output.
// Assumes every field is longer than VOUT_HL ticks.
module vcd_pulse #(
    parameter int HL_W    = 10,
    parameter int VOUT_HL = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hh_en,
    input  logic            end_now,
    input  logic [HL_W-1:0] cnt_q,
    output logic            vreset,
    output logic            vout
);
    // Purpose: register the restart pulse and time the output pulse width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vreset <= 1'b0;
            vout   <= 1'b0;
        end else begin
            vreset <= end_now;
            if (end_now)
                vout <= 1'b1;
            else if (hh_en && cnt_q == HL_W'(VOUT_HL - 1))
                vout <= 1'b0;
        end
    end

    AST_VRESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vreset |=> !vreset); // R2
    AST_VOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vout) |-> vreset); // R7
endmodule

// File: rtl/vcd_status.sv
// Module: vcd_status
// Classifies each ended field (rate and standard length) and tracks lock
// through a saturating counter of consecutive fields without accepted sync.
// Assumes end_now, acc_now and len_now come from the same tick.
module vcd_status #(
    parameter int HL_W       = 10,
    parameter int SPLIT_HL   = 575,
    parameter int F_525      = 525,
    parameter int F_625      = 625,
    parameter int MISS_LIMIT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            end_now,
    input  logic            acc_now,
    input  logic [HL_W-1:0] len_now,
    output logic            is_60hz,
    output logic            nonstd,
    output logic            locked
);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    logic [MW-1:0] miss_q;

    // Purpose: update the flags and the miss count at each field end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_60hz <= 1'b0;
            nonstd  <= 1'b0;
            locked  <= 1'b0;
            miss_q  <= '0;
        end else if (end_now) begin
            is_60hz <= len_now < HL_W'(SPLIT_HL);
            nonstd  <= !(len_now == HL_W'(F_525) || len_now == HL_W'(F_625));
            if (acc_now) begin
                locked <= 1'b1;
                miss_q <= '0;
            end else begin
                if (miss_q >= MW'(MISS_LIMIT - 1)) locked <= 1'b0;
                if (miss_q != MW'(MISS_LIMIT)) miss_q <= miss_q + MW'(1);
            end
        end
    end

    AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(acc_now)); // R10
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !end_now |=> $stable({is_60hz, nonstd, locked})); // R8
endmodule

// File: rtl/vert_countdown.sv
// Module: vert_countdown (top)
// Vertical countdown processor in half-line steps: windowed sync lock,
// free-run and forced field lengths, output pulses and field status.
// Assumes hh_en pulses once per half line in the clk domain.
module vert_countdown #(
    parameter int NARROW_LO = 449,
    parameter int WIDE_LO   = 65,
    parameter int HI_AUTO   = 706,
    parameter int HI_60     = 594,
    parameter int F_525     = 525,
    parameter int F_625     = 625,
    parameter int F_524     = 524,
    parameter int F_624     = 624,
    parameter int SPLIT_HL  = 575,
    parameter int VOUT_HL   = 16,
    parameter int MISS_LIMIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hh_en,
    input  logic       vsync_in,
    input  logic [2:0] mode,
    output logic       vreset,
    output logic       vout,
    output logic       is_60hz,
    output logic       nonstd,
    output logic       locked
);
    localparam int HL_W = $clog2(HI_AUTO + 1);

    logic [HL_W-1:0] lo, limit, cnt_q, len_now;
    logic            sync_en, acc_now, end_now;

    vcd_window #(
        .HL_W(HL_W), .NARROW_LO(NARROW_LO), .WIDE_LO(WIDE_LO),
        .HI_AUTO(HI_AUTO), .HI_60(HI_60), .F_525(F_525), .F_625(F_625),
        .F_524(F_524), .F_624(F_624)
    ) u_win (
        .mode(mode), .lo(lo), .limit(limit), .sync_en(sync_en)
    );

    vcd_counter #(.HL_W(HL_W), .MAX_HL(HI_AUTO)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hh_en(hh_en), .vsync_in(vsync_in),
        .lo(lo), .limit(limit), .sync_en(sync_en), .cnt_q(cnt_q),
        .len_now(len_now), .acc_now(acc_now), .end_now(end_now)
    );

    vcd_pulse #(.HL_W(HL_W), .VOUT_HL(VOUT_HL)) u_pulse (
        .clk(clk), .rst_n(rst_n), .hh_en(hh_en), .end_now(end_now),
        .cnt_q(cnt_q), .vreset(vreset), .vout(vout)
    );

    vcd_status #(
        .HL_W(HL_W), .SPLIT_HL(SPLIT_HL), .F_525(F_525), .F_625(F_625),
        .MISS_LIMIT(MISS_LIMIT)
    ) u_stat (
        .clk(clk), .rst_n(rst_n), .end_now(end_now), .acc_now(acc_now),
        .len_now(len_now), .is_60hz(is_60hz), .nonstd(nonstd), .locked(locked)
    );
endmodule

// File: tb/vert_countdown_test.sv
// Bench: sweeps all eight modes across sync positions around every window
// edge and computes the expected length and flags arithmetically.
module vert_countdown_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hh_en = 1'b1;
    logic       vsync_in = 1'b0;
    logic [2:0] mode = 3'd0;
    logic       vreset, vout, is_60hz, nonstd, locked;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int m_miss = 0;
    int m_locked = 0;

    always #2 clk = ~clk;

    vert_countdown uut (
        .clk(clk), .rst_n(rst_n), .hh_en(hh_en), .vsync_in(vsync_in),
        .mode(mode), .vreset(vreset), .vout(vout), .is_60hz(is_60hz),
        .nonstd(nonstd), .locked(locked)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            failures++;
            $display("FAIL R2 watchdog expired got=%0d exp=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    function automatic int exp_len(input int m, input int s);
        int lo, hi;
        if (m[1]) return m[0] ? (m[2] ? 624 : 625) : (m[2] ? 524 : 525);
        lo = m[2] ? 65 : 449;
        hi = m[0] ? 594 : 706;
        if (s >= lo && s <= hi) return s;
        return hi;
    endfunction

    function automatic int exp_acc(input int m, input int s);
        if (m[1]) return 0;
        return (s != 0 && s >= (m[2] ? 65 : 449) && s <= (m[0] ? 594 : 706)) ? 1 : 0;
    endfunction

    function automatic string len_tag(input int m, input int acc);
        if (m[1]) return "R6 forced length";
        if (!acc) return "R5 free-run length";
        return m[0] ? "R4 60Hz window length" : "R3 auto window length";
    endfunction

    // Starts at a falling edge where vreset is seen; returns at the next one.
    task automatic run_field(input int s, output int len, output int vcnt);
        int k = 0;
        vcnt = 0;
        forever begin
            vsync_in = (s != 0 && k == s - 1);
            if (vout) vcnt++;
            @(negedge clk);
            k++;
            if (vreset || k > 2000) break;
        end
        vsync_in = 1'b0;
        len = k;
    endtask

    initial begin
        int len, vcnt, el, ea;
        int spots[11] = '{0, 64, 65, 300, 448, 449, 525, 594, 595, 625, 706};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 vreset", vreset, 0);
        chk("R1 vout", vout, 0);
        chk("R1 is_60hz", is_60hz, 0);
        chk("R1 nonstd", nonstd, 0);
        chk("R1 locked", locked, 0);
        rst_n = 1'b1;
        while (!vreset) @(negedge clk);
        m_miss = 1;
        for (int m = 0; m < 8; m++) begin
            mode = 3'(m);
            foreach (spots[i]) begin
                run_field(spots[i], len, vcnt);
                el = exp_len(m, spots[i]);
                ea = exp_acc(m, spots[i]);
                if (ea != 0) begin
                    m_locked = 1;
                    m_miss = 0;
                end else begin
                    if (m_miss >= 1) m_locked = 0;
                    if (m_miss < 2) m_miss++;
                end
                chk(len_tag(m, ea), len, el);
                chk("R7 vout width", vcnt, 16);
                chk("R8 is_60hz", is_60hz, (el < 575) ? 1 : 0);
                chk("R9 nonstd", nonstd, (el == 525 || el == 625) ? 0 : 1);
                chk("R10 locked", locked, m_locked);
            end
        end
        // R2: ticks only on hh_en; forced 524 with a tick every second clock.
        mode = 3'd6;
        begin
            int k = 0;
            forever begin
                hh_en = k[0];
                @(negedge clk);
                k++;
                if (vreset || k > 3000) break;
            end
            hh_en = 1'b1;
            chk("R2 gated field clocks", k, 1048);
        end
        @(negedge clk);
        chk("R2 vreset single clock", vreset, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule